// File: doc/BRIEF.md
# Multi-Word Write Buffer Sequencer

This block takes buffered program requests from a flash command bus and passes them on to a program engine. The host issues a setup command together with a start address. It then polls a buffer-free flag and writes a length word that holds the transfer size minus one. Next come that many data writes at consecutive addresses, and last a confirm command. Each confirmed buffer goes to a program port, one word per program interval.

There are two buffer slots. The host can fill a second transfer while the first one is still being programmed. Committed buffers are programmed oldest first. Two kinds of fault end a sequence early and set status error bits:

- a malformed sequence;
- a failed program pulse, which also discards every transfer still waiting.

The array behind the program port is outside this block.

Top module: `wbufSequencer`

## Requirements
- R1: After reset, status reads 0x80 (bit 7 ready, bits 5 and 4 clear), bufFree is 1 and pgmWr is 0.
- R2: The sequence E8h (low byte, with start address S), length L, L+1 data writes and D0h queues L+1 words. The first word leaves on pgmWr in the PROG_CYCLES-th cycle after the confirm edge, and each later word follows PROG_CYCLES cycles after the one before it. Word i goes out with pgmAddr = S+i and its data.
- R3: bufFree is 1 exactly when fewer than two slots are held. A slot counts as held when it is committed, or when it is being filled (from an accepted length write until its confirm or abort).
- R4: A second transfer can be loaded while the first is programming. Transfers are programmed in the order they were confirmed.
- R5: Status bit 7 is 0 from the confirm edge until the last word of the last queued transfer has been programmed.
- R6: A length word greater than DEPTH-1 aborts the sequence, sets status bits 5 and 4, and queues nothing.
- R7: A data write whose address is not S+i for the i-th word aborts the sequence and sets bits 5 and 4.
- R8: Any write other than D0h in the confirm slot aborts the sequence and sets bits 5 and 4.
- R9: When pgmFail is high in a pgmWr cycle, status bit 4 is set. That transfer and any queued transfer are then dropped, so no further pgmWr follows and bit 7 returns to 1.
- R10: Writing 50h while idle clears bits 5 and 4. While either bit is set, E8h is ignored, and so are the writes that follow it.
- R11: A length write made while bufFree is 0 is ignored. The sequence stays waiting for a length, and no error bit is set.
- R12: A transfer whose last address S+L falls in a different 2^BLOCK_W-word block from S aborts at the length write and sets bits 5 and 4. A transfer ending on the last word of the block is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Host write strobe, one cycle per bus write |
| busAddr | input | ADDR_W | Host write address (word) |
| busData | input | DATA_W | Host write data; the command code is in the low byte |
| bufFree | output | 1 | 1 when a buffer slot is available |
| status | output | 8 | Bit 7 ready, bit 5 sequence error, bit 4 program error, other bits 0 |
| pgmWr | output | 1 | One-cycle program request for the array |
| pgmAddr | output | ADDR_W | Address of the word being programmed |
| pgmData | output | DATA_W | Data of the word being programmed |
| pgmFail | input | 1 | Array reports failure of the word offered in this pgmWr cycle |

## Verification
Suppose a slot pointer or the queue count drifts. The effect shows at the ports within one program interval: pgmAddr or pgmData carries a word from the wrong transfer, or status bit 7 and bufFree disagree with the number of confirmed transfers. If the program timer is wrong, a pgmWr pulse arrives one or more cycles early or late. A cycle-exact model is therefore compared against every output on every clock. A broken fill index or address check shows up in one of two ways: error bits set on the next data write when they should stay clear, or a programmed word with the wrong address.

// File: rtl/wbufPkg.sv
package wbufPkg;
  typedef struct packed {
    logic latchStart;
    logic latchCount;
    logic storeData;
    logic commit;
    logic advance;
    logic retire;
    logic flush;
  } wbufStrobes_t;

  localparam logic [7:0] CMD_SETUP   = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
endpackage

// File: rtl/wbufDatapath.sv
module wbufDatapath
  import wbufPkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 16,
  parameter int BLOCK_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  wbufStrobes_t      strobes,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  output logic [1:0]        queued,
  output logic              addrOk,
  output logic              lastFill,
  output logic              lastProg,
  output logic              countBad,
  output logic [ADDR_W-1:0] pgmAddr,
  output logic [DATA_W-1:0] pgmData
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int SLOTS = 2;

  logic [ADDR_W-1:0] fillStart;
  logic [ADDR_W-1:0] endAddr;
  logic [IDX_W-1:0]  fillIdx;
  logic [IDX_W-1:0]  fillCnt;
  logic [IDX_W-1:0]  progIdx;
  logic              wp;
  logic              rp;
  logic              wpNext;

  logic [ADDR_W-1:0] bufStart [SLOTS];
  logic [IDX_W-1:0]  bufCnt   [SLOTS];
  logic [DATA_W-1:0] bufMem   [SLOTS][DEPTH];

  assign wpNext   = wp ^ strobes.commit;
  assign endAddr  = fillStart + ADDR_W'(busData[IDX_W-1:0]);
  assign countBad = (busData > DATA_W'(DEPTH - 1)) ||
                    (fillStart[ADDR_W-1:BLOCK_W] != endAddr[ADDR_W-1:BLOCK_W]);
  assign addrOk   = (busAddr == fillStart + ADDR_W'(fillIdx));
  assign lastFill = (fillIdx == fillCnt);
  assign lastProg = (progIdx == bufCnt[rp]);
  assign pgmAddr  = bufStart[rp] + ADDR_W'(progIdx);
  assign pgmData  = bufMem[rp][progIdx];

  // fill side and slot pointers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillStart <= '0;
      fillIdx   <= '0;
      fillCnt   <= '0;
      wp        <= 1'b0;
      rp        <= 1'b0;
      queued    <= '0;
      progIdx   <= '0;
    end else begin
      if (strobes.latchStart) fillStart <= busAddr;
      if (strobes.latchCount) begin
        fillCnt <= busData[IDX_W-1:0];
        fillIdx <= '0;
      end else if (strobes.storeData) begin
        fillIdx <= fillIdx + IDX_W'(1);
      end
      wp <= wpNext;
      if (strobes.flush) begin
        // discard everything committed, including a same-cycle commit
        rp      <= wpNext;
        queued  <= '0;
        progIdx <= '0;
      end else begin
        queued <= queued + {1'b0, strobes.commit} - {1'b0, strobes.retire};
        if (strobes.retire) begin
          rp      <= ~rp;
          progIdx <= '0;
        end else if (strobes.advance) begin
          progIdx <= progIdx + IDX_W'(1);
        end
      end
    end
  end

  // slot storage, no reset needed
  always_ff @(posedge clk) begin
    if (strobes.latchCount) begin
      bufStart[wp] <= fillStart;
      bufCnt[wp]   <= busData[IDX_W-1:0];
    end
    if (strobes.storeData) bufMem[wp][fillIdx] <= busData;
  end
endmodule

// File: rtl/wbufCtrl.sv
module wbufCtrl
  import wbufPkg::*;
#(
  parameter int PROG_CYCLES = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         busWr,
  input  logic [7:0]   cmd,
  input  logic         pgmFail,
  input  logic [1:0]   queued,
  input  logic         addrOk,
  input  logic         lastFill,
  input  logic         lastProg,
  input  logic         countBad,
  output wbufStrobes_t strobes,
  output logic         pgmWr,
  output logic         bufFree,
  output logic [7:0]   status
);
  localparam int TMR_W = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1;

  typedef enum logic [1:0] {HS_IDLE, HS_COUNT, HS_DATA, HS_CONFIRM} hostState_t;

  hostState_t       hostState;
  hostState_t       hostNext;
  logic [TMR_W-1:0] timer;
  logic             seqErr;
  logic             progErr;
  logic             doAbort;
  logic             doClear;
  logic             filling;
  logic             fire;

  assign filling = (hostState == HS_DATA) || (hostState == HS_CONFIRM);
  assign bufFree = ({1'b0, queued} + {2'b00, filling}) < 3'd2;
  assign fire    = (queued != 2'd0) && (timer == TMR_W'(PROG_CYCLES - 1));
  assign pgmWr   = fire;
  assign status  = {(queued == 2'd0), 1'b0, seqErr, progErr, 4'b0000};

  always_comb begin
    hostNext = hostState;
    doAbort  = 1'b0;
    doClear  = 1'b0;
    strobes  = '0;
    if (busWr) begin
      case (hostState)
        HS_IDLE: begin
          if (cmd == CMD_SETUP && !seqErr && !progErr) begin
            strobes.latchStart = 1'b1;
            hostNext = HS_COUNT;
          end else if (cmd == CMD_CLEAR) begin
            doClear = 1'b1;
          end
        end
        HS_COUNT: begin
          if (bufFree) begin
            if (countBad) begin
              doAbort = 1'b1;
            end else begin
              strobes.latchCount = 1'b1;
              hostNext = HS_DATA;
            end
          end
        end
        HS_DATA: begin
          if (addrOk) begin
            strobes.storeData = 1'b1;
            if (lastFill) hostNext = HS_CONFIRM;
          end else begin
            doAbort = 1'b1;
          end
        end
        HS_CONFIRM: begin
          if (cmd == CMD_CONFIRM) begin
            strobes.commit = 1'b1;
            hostNext = HS_IDLE;
          end else begin
            doAbort = 1'b1;
          end
        end
      endcase
    end
    if (doAbort) hostNext = HS_IDLE;
    strobes.flush   = fire & pgmFail;
    strobes.advance = fire & ~pgmFail & ~lastProg;
    strobes.retire  = fire & ~pgmFail & lastProg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostState <= HS_IDLE;
      timer     <= '0;
      seqErr    <= 1'b0;
      progErr   <= 1'b0;
    end else begin
      hostState <= hostNext;
      if (queued == 2'd0 || fire) timer <= '0;
      else                         timer <= timer + TMR_W'(1);
      seqErr  <= (seqErr & ~doClear) | doAbort;
      progErr <= (progErr & ~doClear) | doAbort | strobes.flush;
    end
  end
endmodule

// File: rtl/wbufSequencer.sv
module wbufSequencer
  import wbufPkg::*;
#(
  parameter int ADDR_W      = 21,
  parameter int DATA_W      = 16,
  parameter int DEPTH       = 16,
  parameter int BLOCK_W     = 15,
  parameter int PROG_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  output logic              bufFree,
  output logic [7:0]        status,
  output logic              pgmWr,
  output logic [ADDR_W-1:0] pgmAddr,
  output logic [DATA_W-1:0] pgmData,
  input  logic              pgmFail
);
  wbufStrobes_t strobes;
  logic [1:0]   queued;
  logic         addrOk;
  logic         lastFill;
  logic         lastProg;
  logic         countBad;

  wbufCtrl #(.PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .cmd(busData[7:0]),
    .pgmFail(pgmFail), .queued(queued), .addrOk(addrOk),
    .lastFill(lastFill), .lastProg(lastProg), .countBad(countBad),
    .strobes(strobes), .pgmWr(pgmWr), .bufFree(bufFree), .status(status)
  );

  wbufDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
                 .BLOCK_W(BLOCK_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busAddr(busAddr),
    .busData(busData), .queued(queued), .addrOk(addrOk),
    .lastFill(lastFill), .lastProg(lastProg), .countBad(countBad),
    .pgmAddr(pgmAddr), .pgmData(pgmData)
  );
endmodule

// File: rtl/wbufChecker.sv
module wbufChecker (
  input logic clk,
  input logic rstN,
  input logic pgmWr,
  input logic pgmFail,
  input logic ready,
  input logic seqErr,
  input logic progErr,
  input logic bufFree
);
  // R3: an empty queue always leaves a slot free
  a_r3_free_when_ready: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> bufFree);
  // R5: never ready while a word is being offered
  a_r5_busy_while_programming: assert property (@(posedge clk) disable iff (!rstN)
    pgmWr |-> !ready);
  // R2: program requests are single-cycle pulses
  a_r2_pulse_spacing: assert property (@(posedge clk) disable iff (!rstN)
    pgmWr |=> !pgmWr);
  // R9: a failed word sets the program error bit
  a_r9_fail_sets_error: assert property (@(posedge clk) disable iff (!rstN)
    (pgmWr && pgmFail) |=> progErr);
  // R9: a failed word empties the queue
  a_r9_fail_flushes: assert property (@(posedge clk) disable iff (!rstN)
    (pgmWr && pgmFail) |=> ready);
  // R6: a sequence error always comes with the program error bit
  a_r6_errors_paired: assert property (@(posedge clk) disable iff (!rstN)
    seqErr |-> progErr);
endmodule

bind wbufSequencer wbufChecker u_chk (
  .clk(clk), .rstN(rstN), .pgmWr(pgmWr), .pgmFail(pgmFail),
  .ready(status[7]), .seqErr(status[5]), .progErr(status[4]),
  .bufFree(bufFree)
);

// File: tb/tb_wbufSequencer.sv
module tb_wbufSequencer;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam int P  = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWr = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busData = '0;
  logic          bufFree;
  logic [7:0]    status;
  logic          pgmWr;
  logic [AW-1:0] pgmAddr;
  logic [DW-1:0] pgmData;
  logic          failArm = 1'b0;
  logic          pgmFail;

  assign pgmFail = failArm;
  always #5 clk = ~clk;

  wbufSequencer dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busData(busData), .bufFree(bufFree), .status(status), .pgmWr(pgmWr),
    .pgmAddr(pgmAddr), .pgmData(pgmData), .pgmFail(pgmFail)
  );

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int            hs = 0;  // 0 idle, 1 length, 2 data, 3 confirm
  logic [AW-1:0] mStart;
  int            mCnt, mIdx;
  logic [DW-1:0] mFill[$];
  logic [AW-1:0] qStart[$];
  int            qCnt[$];
  logic [DW-1:0] qWords[$];
  int            pIdx = 0;
  int            tmr = 0;
  bit            mSeq = 0, mProg = 0;
  logic [AW-1:0] logA[$];
  logic [DW-1:0] logD[$];

  function automatic bit expFree();
    return (qCnt.size() + ((hs == 2 || hs == 3) ? 1 : 0)) < 2;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      hs = 0; pIdx = 0; tmr = 0; mSeq = 0; mProg = 0;
      qStart.delete(); qCnt.delete(); qWords.delete(); mFill.delete();
    end else begin
      int  szPre;
      bit  fire, fl, freeNow, ab, clr;
      logic [AW-1:0] e;
      szPre   = qCnt.size();
      fire    = (szPre > 0) && (tmr == P - 1);
      fl      = fire && pgmFail;
      freeNow = expFree();
      ab = 0; clr = 0;
      if (busWr) begin
        case (hs)
          0: if (busData[7:0] == 8'hE8 && !mSeq && !mProg) begin
               mStart = busAddr; hs = 1;
             end else if (busData[7:0] == 8'h50) clr = 1;
          1: if (freeNow) begin
               e = mStart + AW'(busData[3:0]);
               if (busData > 15 || mStart[AW-1:15] != e[AW-1:15]) ab = 1;
               else begin mCnt = int'(busData); mIdx = 0; mFill.delete(); hs = 2; end
             end
          2: if (busAddr == mStart + AW'(mIdx)) begin
               mFill.push_back(busData);
               if (mIdx == mCnt) hs = 3; else mIdx++;
             end else ab = 1;
          default: if (busData[7:0] == 8'hD0) begin
               qStart.push_back(mStart); qCnt.push_back(mCnt);
               foreach (mFill[k]) qWords.push_back(mFill[k]);
               hs = 0;
             end else ab = 1;
        endcase
      end
      if (clr) begin mSeq = 0; mProg = 0; end
      if (ab)  begin mSeq = 1; mProg = 1; hs = 0; end
      if (fl) begin
        mProg = 1; qStart.delete(); qCnt.delete(); qWords.delete();
        pIdx = 0; tmr = 0;
      end else if (fire) begin
        void'(qWords.pop_front());
        if (pIdx == qCnt[0]) begin
          void'(qStart.pop_front()); void'(qCnt.pop_front()); pIdx = 0;
        end else pIdx++;
        tmr = 0;
      end else tmr = (szPre > 0) ? tmr + 1 : 0;
    end
  end

  always @(posedge clk) if (pgmWr && pgmFail) failArm <= 1'b0;

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit efire;
      logic [7:0] est;
      efire = (qCnt.size() > 0) && (tmr == P - 1);
      est   = {qCnt.size() == 0, 1'b0, mSeq, mProg, 4'b0000};
      chk(pgmWr == efire, "R2 pgmWr timing", pgmWr, efire);
      if (efire && pgmWr) begin
        chk(pgmAddr == qStart[0] + AW'(pIdx), "R2 pgmAddr", pgmAddr, qStart[0] + AW'(pIdx));
        chk(pgmData == qWords[0], "R4 pgmData order", pgmData, qWords[0]);
      end
      chk(status == est, "R5 status", status, est);
      chk(bufFree == expFree(), "R3 bufFree", bufFree, expFree());
      if (pgmWr) begin logA.push_back(pgmAddr); logD.push_back(pgmData); end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = a; busData = d;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic loadBuf(input logic [AW-1:0] a, input int n, input logic [DW-1:0] base);
    wr(a, 16'h00E8);
    wr(a, DW'(n - 1));
    for (int i = 0; i < n; i++) wr(a + AW'(i), base + DW'(i));
    wr(a, 16'h00D0);
  endtask

  task automatic waitReady();
    for (int g = 0; g < 2000 && !status[7]; g++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(status == 8'h80, "R1 status", status, 8'h80);
    chk(bufFree == 1'b1, "R1 bufFree", bufFree, 1);
    chk(pgmWr == 1'b0, "R1 pgmWr", pgmWr, 0);

    // R2 single transfer
    base = logA.size();
    loadBuf(21'h100, 4, 16'h1100);
    chk(status[7] == 1'b0, "R5 busy after confirm", status[7], 0);
    waitReady();
    chk(logA.size() - base == 4, "R2 word count", logA.size() - base, 4);
    for (int i = 0; i < 4 && base + i < logA.size(); i++) begin
      chk(logA[base+i] == 21'h100 + AW'(i), "R2 address", logA[base+i], 21'h100 + i);
      chk(logD[base+i] == 16'h1100 + DW'(i), "R2 data", logD[base+i], 16'h1100 + i);
    end

    // R4 / R3 / R11 double buffering
    base = logA.size();
    loadBuf(21'h200, 4, 16'hA000);
    wr(21'h300, 16'h00E8);
    chk(bufFree == 1'b1, "R3 second slot free", bufFree, 1);
    wr(21'h300, 16'd1);
    wr(21'h300, 16'hB000);
    wr(21'h301, 16'hB001);
    wr(21'h300, 16'h00D0);
    chk(bufFree == 1'b0, "R3 both slots held", bufFree, 0);
    wr(21'h380, 16'h00E8);
    wr(21'h380, 16'd0);
    chk(status[5:4] == 2'b00, "R11 length ignored, no error", status[5:4], 0);
    for (int g = 0; g < 500 && !bufFree; g++) @(negedge clk);
    wr(21'h380, 16'd0);
    wr(21'h380, 16'hC000);
    wr(21'h380, 16'h00D0);
    waitReady();
    chk(logA.size() - base == 7, "R4 word count", logA.size() - base, 7);
    if (logA.size() - base == 7) begin
      chk(logA[base+3] == 21'h203, "R4 first transfer last", logA[base+3], 21'h203);
      chk(logA[base+4] == 21'h300, "R4 second transfer first", logA[base+4], 21'h300);
      chk(logD[base+6] == 16'hC000, "R11 retried transfer", logD[base+6], 16'hC000);
    end

    // R6 oversize length, then R10 lockout and clear
    base = logA.size();
    wr(21'h10, 16'h00E8);
    wr(21'h10, 16'd16);
    chk(status == 8'hB0, "R6 abort status", status, 8'hB0);
    wr(21'h10, 16'h00E8);
    wr(21'h10, 16'd0);
    wr(21'h10, 16'h1234);
    wr(21'h10, 16'h00D0);
    idle(20);
    chk(logA.size() == base, "R10 E8 ignored while error", logA.size() - base, 0);
    chk(status == 8'hB0, "R10 status held", status, 8'hB0);
    wr(21'h0, 16'h0050);
    chk(status == 8'h80, "R10 clear", status, 8'h80);

    // R7 out-of-sequence address
    wr(21'h400, 16'h00E8);
    wr(21'h400, 16'd1);
    wr(21'h400, 16'h4000);
    wr(21'h402, 16'h4001);
    idle(20);
    chk(status == 8'hB0, "R7 abort status", status, 8'hB0);
    chk(logA.size() == base, "R7 nothing programmed", logA.size() - base, 0);
    wr(21'h0, 16'h0050);

    // R8 bad confirm
    wr(21'h410, 16'h00E8);
    wr(21'h410, 16'd0);
    wr(21'h410, 16'h4100);
    wr(21'h410, 16'h00FF);
    idle(20);
    chk(status == 8'hB0, "R8 abort status", status, 8'hB0);
    chk(logA.size() == base, "R8 nothing programmed", logA.size() - base, 0);
    wr(21'h0, 16'h0050);

    // R12 block boundary
    wr(21'h7FFE, 16'h00E8);
    wr(21'h7FFE, 16'd3);
    chk(status == 8'hB0, "R12 crossing aborts", status, 8'hB0);
    wr(21'h0, 16'h0050);
    loadBuf(21'h7FFC, 4, 16'h7000);
    waitReady();
    chk(logA.size() - base == 4, "R12 ending on block edge", logA.size() - base, 4);
    chk(status == 8'h80, "R12 no error", status, 8'h80);

    // R9 program failure flushes queue
    base = logA.size();
    loadBuf(21'h500, 4, 16'h5000);
    loadBuf(21'h600, 2, 16'h6000);
    base = logA.size();
    @(negedge clk); failArm = 1'b1;
    idle(150);
    chk(logA.size() - base == 1, "R9 no words after failure", logA.size() - base, 1);
    chk(status == 8'h90, "R9 status", status, 8'h90);
    wr(21'h0, 16'h0050);
    chk(status == 8'h80, "R10 clear after failure", status, 8'h80);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule